// File: doc/BRIEF.md
# Parity Error Accumulation Counter

This block keeps a running total of B1 parity mismatches seen on a received SONET STS-1/STS-3 stream. Once per frame the receive path raises a one-cycle strobe together with an 8-bit mismatch mask. The mask is the XOR of the received B1 byte and the locally computed BIP-8, so each set bit marks one erred parity bit. A mode input selects what is added per frame. In per-bit mode the number of set mask bits is added. In per-frame mode one is added for any frame whose mask is nonzero.

Software reads the count through a byte-wide register port: an address, a read strobe and 8-bit read data. Four consecutive addresses expose the 32-bit count, with the most significant byte at the lowest address. Reading the most significant byte takes a snapshot of the whole count and clears the live counter. The three lower bytes are then read from that snapshot, so one pass of four reads returns a consistent value while counting goes on.

Top module: `parity_err_counter`

## Requirements
- R1: After reset the live counter, the snapshot and `rd_data` are all zero.
- R2: Address `BASE_ADDR`+0 returns count bits 31:24, +1 bits 23:16, +2 bits 15:8 and +3 bits 7:0; with the default base these are 0x210 to 0x213. `rd_data` is valid on the clock after `rd_en`. An address outside this window reads 0x00, and `rd_data` holds its value when no read is made.
- R3: With `per_bit_mode`=1, a strobed frame adds the number of set bits in `err_mask` (0 to 8) to the count.
- R4: A cycle without `frame_stb`, or a strobed frame whose `err_mask` is 0x00, leaves the count unchanged in both modes.
- R5: With `per_bit_mode`=0, a strobed frame with any nonzero `err_mask` adds exactly one, however many bits are set.
- R6: The count saturates at its all-ones value (0xFFFFFFFF for the default `CNT_W`=32) and never wraps.
- R7: A read at offset +0 returns live bits 31:24, copies the full live count into the snapshot, and clears the live counter.
- R8: A read at offsets +1, +2 or +3 returns the matching byte of the snapshot and then clears that snapshot byte. A second read of the same byte returns 0x00.
- R9: An increment in the same cycle as an offset +0 read is added to the freshly cleared counter and is not lost.
- R10: The value of `per_bit_mode` in a cycle with `frame_stb` decides how that frame is counted. Changing it between strobes has no effect on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| err_mask | input | 8 | B1 versus BIP-8 mismatch mask, valid with `frame_stb` |
| per_bit_mode | input | 1 | 1: count erred bits; 0: count erred frames |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, valid one clock after `rd_en` |

## Verification
On every cycle the assertions check several properties of the live counter. It never decreases except through an offset +0 read. It stays put when no erred frame arrives. It grows by at most eight per frame, or by at most one in per-frame mode, and it is zero right after a clearing read that has no coincident frame. Unmapped reads returning zero is also checked every cycle. The exact totals, the byte order of the map, snapshot coherence across a four-read pass, the clearing of snapshot bytes, the coincident read and increment, mode sampling and saturation can only be shown by the bench's scenarios. These are compared cycle by cycle against a behavioural model, including a second instance with a narrow counter that can be driven into saturation.

// File: rtl/parity_err_counter.sv
module parity_err_counter #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [7:0]        err_mask,
  input  logic              per_bit_mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, snap, cnt_nxt;
  logic [3:0]       pop;
  logic [7:0]       rd_byte;
  logic [31:0]      keep_mask;

  always_comb begin
    pop = '0;
    for (int i = 0; i < 8; i++) pop = pop + 4'(err_mask[i]);
  end

  wire [3:0]        step    = !frame_stb ? 4'd0 : per_bit_mode ? pop : {3'b0, |err_mask};
  wire [ADDR_W-1:0] off     = rd_addr - BASE_ADDR;
  wire              hit     = rd_en && (off < ADDR_W'(4));
  wire              snap_rd = hit && (off[1:0] == 2'd0);
  wire [CNT_W:0]    sum     = {1'b0, snap_rd ? '0 : cnt} + (CNT_W+1)'(step);
  wire [31:0]       cnt32   = 32'(cnt);
  wire [31:0]       snap32  = 32'(snap);

  assign cnt_nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_comb begin
    case (off[1:0])
      2'd0:    begin rd_byte = cnt32[31:24];  keep_mask = 32'hFFFF_FFFF; end
      2'd1:    begin rd_byte = snap32[23:16]; keep_mask = 32'hFF00_FFFF; end
      2'd2:    begin rd_byte = snap32[15:8];  keep_mask = 32'hFFFF_00FF; end
      default: begin rd_byte = snap32[7:0];   keep_mask = 32'hFFFF_FF00; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      snap    <= '0;
      rd_data <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (rd_en) rd_data <= hit ? rd_byte : 8'h00;
      if (snap_rd)  snap <= cnt;
      else if (hit) snap <= CNT_W'(snap32 & keep_mask);
    end
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_rd |=> cnt >= $past(cnt));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_rd |=> (cnt - $past(cnt)) <= CNT_W'(8));

  // R5
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_rd && !per_bit_mode) |=> (cnt - $past(cnt)) <= CNT_W'(1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_rd && (!frame_stb || err_mask == 8'h00)) |=> $stable(cnt));

  // R7
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_rd && !frame_stb) |=> cnt == '0);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rd_data == 8'h00);

endmodule

// File: tb/parity_err_counter_tb.sv
module parity_err_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SAT_W = 10;

  logic clk = 0, rst_n = 0;
  logic frame_stb = 0, per_bit_mode = 0, rd_en = 0;
  logic [7:0] err_mask = 0;
  logic [11:0] rd_addr = 0;
  logic [7:0] rd_main, rd_sat;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_err_counter u_dut (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .err_mask(err_mask),
    .per_bit_mode(per_bit_mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_main));
  parity_err_counter #(.CNT_W(SAT_W)) u_sat (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .err_mask(err_mask), .per_bit_mode(per_bit_mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_sat));

  longint m_cnt[2], m_snap[2], m_max[2];
  logic [7:0] m_rd[2];
  initial begin
    m_max[0] = 64'hFFFF_FFFF;
    m_max[1] = (64'd1 << SAT_W) - 1;
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cnt[i] = 0; m_snap[i] = 0; m_rd[i] = 0;
      end else begin
        longint base, inc, nv;
        int off;
        bit in_win;
        off = int'(rd_addr) - 'h210;
        in_win = rd_en && off >= 0 && off < 4;
        base = (in_win && off == 0) ? 0 : m_cnt[i];
        inc = 0;
        if (frame_stb) begin
          if (per_bit_mode) begin
            for (int b = 0; b < 8; b++) inc += err_mask[b];
          end else inc = (err_mask != 0) ? 1 : 0;
        end
        nv = base + inc;
        if (nv > m_max[i]) nv = m_max[i];
        if (rd_en && !in_win) m_rd[i] = 8'h00;
        if (in_win) begin
          if (off == 0) begin
            m_rd[i] = 8'((m_cnt[i] >> 24) & 'hFF);
            m_snap[i] = m_cnt[i];
          end else begin
            int sh;
            sh = 8 * (3 - off);
            m_rd[i] = 8'((m_snap[i] >> sh) & 'hFF);
            m_snap[i] = m_snap[i] & ~(longint'('hFF) << sh);
          end
        end
        m_cnt[i] = nv;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (rd_main !== m_rd[0]) begin
        miscompares++;
        $display("FAIL %s main: rd_data=%02h expected=%02h at t=%0t", cur_req, rd_main, m_rd[0], $time);
      end
      vectors++;
      if (rd_sat !== m_rd[1]) begin
        miscompares++;
        $display("FAIL %s sat: rd_data=%02h expected=%02h at t=%0t", cur_req, rd_sat, m_rd[1], $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic cyc(input bit fs, input logic [7:0] m, input bit pb, input bit re, input logic [11:0] a);
    frame_stb = fs; err_mask = m; per_bit_mode = pb; rd_en = re; rd_addr = a;
    @(negedge clk);
  endtask

  task automatic read_all();
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 12'h210 + 12'(k));
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0);
    read_all();

    cur_req = "R3";
    cyc(1, 8'hFF, 1, 0, 0);
    cyc(1, 8'h81, 1, 0, 0);
    cyc(1, 8'h10, 1, 0, 0);
    read_all();

    cur_req = "R4";
    cyc(1, 8'h00, 1, 0, 0);
    cyc(0, 8'hFF, 1, 0, 0);
    cyc(1, 8'h00, 0, 0, 0);
    cyc(0, 8'hFF, 0, 0, 0);
    read_all();

    cur_req = "R5";
    cyc(1, 8'hFF, 0, 0, 0);
    cyc(1, 8'h01, 0, 0, 0);
    cyc(1, 8'h00, 0, 0, 0);
    read_all();

    cur_req = "R10";
    cyc(0, 8'h00, 1, 0, 0);
    cyc(1, 8'h0F, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0);
    cyc(1, 8'h0F, 1, 0, 0);
    read_all();

    cur_req = "R9";
    cyc(1, 8'h07, 1, 0, 0);
    cyc(1, 8'h03, 1, 1, 12'h210);
    read_all();

    cur_req = "R8";
    for (int n = 0; n < 300; n++) cyc(1, 8'hFF, 1, 0, 0);
    cyc(0, 0, 0, 1, 12'h210);
    cyc(1, 8'hFF, 1, 1, 12'h212);
    cyc(0, 0, 0, 1, 12'h212);
    cyc(0, 0, 0, 1, 12'h213);
    cyc(0, 0, 0, 1, 12'h213);
    cyc(0, 0, 0, 1, 12'h211);
    read_all();

    cur_req = "R7";
    cyc(1, 8'h3C, 1, 1, 12'h210);
    cyc(0, 0, 0, 1, 12'h210);
    read_all();

    cur_req = "R2";
    cyc(1, 8'hAA, 1, 0, 0);
    cyc(0, 0, 0, 1, 12'h214);
    cyc(0, 0, 0, 1, 12'h20F);
    cyc(0, 0, 0, 1, 12'h000);
    cyc(0, 0, 0, 1, 12'h210);
    cyc(0, 0, 0, 0, 12'h213);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h213);
    cyc(0, 0, 0, 0, 0);

    cur_req = "R6";
    for (int n = 0; n < 140; n++) cyc(1, 8'hFF, 1, 0, 0);
    cyc(1, 8'hFF, 0, 0, 0);
    read_all();
    for (int n = 0; n < 140; n++) cyc(1, 8'hF0, 1, n == 70, 12'h210);
    read_all();

    cur_req = "R1";
    rst_n = 0;
    cyc(0, 0, 0, 0, 0);
    rst_n = 1;
    read_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule